// File: doc/BRIEF.md
# Automatic Serial Flow Controller

This block starts and stops serial traffic in both directions with no processor involvement. On the receive side it watches how full the receive queue is. When the queue fills to a programmed halt level, it tells the far end to stop sending. Once the queue has drained to a programmed resume level, it tells the far end to send again. The far end is told either by dropping and raising the RTS line (hardware handshake) or by asking the local transmitter to insert Xoff and Xon characters (in-band handshake).

On the transmit side it holds back new data characters while the far end's CTS line is inactive, or after an Xoff character has arrived, until CTS returns or an Xon arrives. A character already on the line is allowed to finish, because the gate only governs when a new data character may start. Received Xon and Xoff characters are absorbed here and never reach the receive queue. Both schemes sit behind a master extended-feature enable, and each can be turned on separately. Both thresholds are 4-bit fields counted in steps of four queue entries.

Top module: `flow_ctl_top`

## Requirements
- R1: During and right after reset, rts_out is 1, tx_gate is 0, ctl_req is 0 and rxq_wr_en is 0.
- R2: With the hardware scheme active (cfg_ext_en=1, cfg_hw_en=1) and cfg_halt_lvl nonzero, rts_out goes to 0 on the clock edge that samples rxq_level >= 4*cfg_halt_lvl. Below that level rts_out stays 1.
- R3: Once halted, rts_out stays 0 while rxq_level > 4*cfg_resume_lvl. It returns to 1 on the edge that samples rxq_level <= 4*cfg_resume_lvl.
- R4: With the hardware scheme active, tx_gate is 0 one edge after cts_in is sampled 0, and it is 1 again one edge after cts_in is sampled 1 (when nothing else holds the gate).
- R5: With the in-band scheme active (cfg_ext_en=1, cfg_sw_en=1), crossing the halt level raises ctl_req with ctl_char=cfg_xoff two edges after the level is sampled. Falling to the resume level raises ctl_req with ctl_char=cfg_xon. rts_out stays 1 unless the hardware scheme is also on.
- R6: ctl_req stays 1 until ctl_ack is sampled 1, and drops on that edge. If a new halt or resume event occurs while a request is pending, the request stays up and ctl_char changes to the new character.
- R7: While ctl_req is 1, tx_gate is 0, so a pending Xoff or Xon goes out ahead of the next data character.
- R8: With the in-band scheme active, a received character equal to cfg_xoff (rx_valid=1) drops tx_gate two edges later. A received cfg_xon raises it two edges later. With the in-band scheme off, these characters have no effect on tx_gate.
- R9: A received character is written to the queue (rxq_wr_en=1, rxq_wr_data=rx_char) one edge after rx_valid, unless the in-band scheme is active and the character equals cfg_xon or cfg_xoff. In that case it is not written.
- R10: With cfg_ext_en=0 both schemes are off. rts_out stays 1, cts_in and received characters do not affect tx_gate, and every received character is written.
- R11: A cfg_halt_lvl of 0 disables the halt. rts_out stays 1 and no Xoff is requested, even with a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ext_en | input | 1 | Master enable for both flow-control schemes |
| cfg_hw_en | input | 1 | Select the RTS/CTS handshake |
| cfg_sw_en | input | 1 | Select the Xon/Xoff handshake |
| cfg_halt_lvl | input | 4 | Halt threshold, in steps of 4 entries (0 disables) |
| cfg_resume_lvl | input | 4 | Resume threshold, in steps of 4 entries |
| cfg_xon | input | 8 | Resume character value |
| cfg_xoff | input | 8 | Pause character value |
| rxq_level | input | 7 | Current receive-queue occupancy |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Received character |
| cts_in | input | 1 | Far end clear to send, 1 = clear |
| ctl_ack | input | 1 | Transmitter accepted the pending control character |
| rts_out | output | 1 | Ready to receive, 1 = send allowed |
| tx_gate | output | 1 | A new data character may start |
| ctl_req | output | 1 | Request to send ctl_char ahead of data |
| ctl_char | output | 8 | Control character to send |
| rxq_wr_en | output | 1 | Write strobe into the receive queue |
| rxq_wr_data | output | 8 | Character written into the receive queue |

## Verification
The occupancy thresholds are tested with levels just below the halt point, exactly at it, between the two thresholds and exactly at the resume point. This shows the hysteresis apart from a single-threshold compare. The in-band scheme is tested with a lone halt, a lone resume, and a resume that is overtaken by a new halt before it is acknowledged. These cases separate holding a request, replacing its character and releasing it. Xon, Xoff and ordinary characters are sent with the in-band scheme on, with it off, and with the master enable off. A scoreboard of expected queue writes then shows that only control characters are filtered, and only when the scheme is active. A halt field of zero and a cleared master enable confirm that the outputs stay at their idle values.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int CHAR_W  = 8;
  localparam int THR_W   = 4;
  localparam int UNIT_SH = 2;
endpackage

// File: rtl/fc_rx_thresh.sv
module fc_rx_thresh #(
  parameter int LVL_W   = 7,
  parameter int THR_W   = fc_pkg::THR_W,
  parameter int UNIT_SH = fc_pkg::UNIT_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             hw_act,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] halt_f,
  input  logic [THR_W-1:0] resume_f,
  output logic             halted,
  output logic             halt_evt,
  output logic             resume_evt,
  output logic             rts
);
  localparam int TW    = THR_W + UNIT_SH;
  localparam int CMP_W = (LVL_W > TW) ? LVL_W : TW;

  logic [CMP_W-1:0] lvl_e, halt_e, res_e;
  logic go_halt, go_res, halted_d;

  assign lvl_e  = CMP_W'(level);
  assign halt_e = CMP_W'(halt_f) << UNIT_SH;
  assign res_e  = CMP_W'(resume_f) << UNIT_SH;

  assign go_halt  = enable && (halt_f != '0) && !halted && (lvl_e >= halt_e);
  assign go_res   = halted && (!enable || (halt_f == '0) || (lvl_e <= res_e));
  assign halted_d = go_halt || (halted && !go_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      halt_evt   <= 1'b0;
      resume_evt <= 1'b0;
      rts        <= 1'b1;
    end else begin
      halted     <= halted_d;
      halt_evt   <= go_halt;
      resume_evt <= go_res;
      rts        <= !(hw_act && halted_d);
    end
  end

  // R2: rts only falls after the halt level was reached
  p_rts_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rts) |-> $past(lvl_e >= halt_e));
  // R3: no release while above the resume level
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (halted && enable && halt_f != '0 && lvl_e > res_e) |=> halted);
  // R11: zero halt field never halts
  p_zero_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (halt_f == '0) |=> !halt_evt);
endmodule

// File: rtl/fc_sw_link.sv
module fc_sw_link #(
  parameter int CHAR_W = fc_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_act,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [CHAR_W-1:0] xon,
  input  logic [CHAR_W-1:0] xoff,
  output logic              paused,
  output logic              wr_en,
  output logic [CHAR_W-1:0] wr_data
);
  logic hit_on, hit_off;

  assign hit_on  = sw_act && rx_valid && (rx_char == xon);
  assign hit_off = sw_act && rx_valid && (rx_char == xoff);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      if (!sw_act)      paused <= 1'b0;
      else if (hit_off) paused <= 1'b1;
      else if (hit_on)  paused <= 1'b0;
      wr_en   <= rx_valid && !hit_on && !hit_off;
      wr_data <= rx_char;
    end
  end

  // R9: control characters never reach the queue while in-band mode is on
  p_filter_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sw_act && $past(sw_act)) |-> (wr_data != xon && wr_data != xoff));
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate #(
  parameter int CHAR_W = fc_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_act,
  input  logic              sw_act,
  input  logic              cts,
  input  logic              paused,
  input  logic              halt_evt,
  input  logic              resume_evt,
  input  logic              ack,
  input  logic [CHAR_W-1:0] xon,
  input  logic [CHAR_W-1:0] xoff,
  output logic              req,
  output logic [CHAR_W-1:0] req_char,
  output logic              gate
);
  logic              req_d;
  logic [CHAR_W-1:0] char_d;

  always_comb begin
    req_d  = req;
    char_d = req_char;
    if (!sw_act) begin
      req_d = 1'b0;
    end else if (halt_evt) begin
      req_d  = 1'b1;
      char_d = xoff;
    end else if (resume_evt) begin
      req_d  = 1'b1;
      char_d = xon;
    end else if (ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      req_char <= '0;
      gate     <= 1'b0;
    end else begin
      req      <= req_d;
      req_char <= char_d;
      gate     <= (!hw_act || cts) && (!sw_act || !paused) && !req_d;
    end
  end

  // R7: control character has priority over data
  p_req_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    req |-> !gate);
  // R6: a request is held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && sw_act) |=> req);
  // R4: inactive CTS closes the gate
  p_cts_r4: assert property (@(posedge clk) disable iff (rst)
    (hw_act && !cts) |=> !gate);
endmodule

// File: rtl/flow_ctl_top.sv
module flow_ctl_top #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CW    = fc_pkg::CHAR_W,
  localparam int TW    = fc_pkg::THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ext_en,
  input  logic             cfg_hw_en,
  input  logic             cfg_sw_en,
  input  logic [TW-1:0]    cfg_halt_lvl,
  input  logic [TW-1:0]    cfg_resume_lvl,
  input  logic [CW-1:0]    cfg_xon,
  input  logic [CW-1:0]    cfg_xoff,
  input  logic [LVL_W-1:0] rxq_level,
  input  logic             rx_valid,
  input  logic [CW-1:0]    rx_char,
  input  logic             cts_in,
  input  logic             ctl_ack,
  output logic             rts_out,
  output logic             tx_gate,
  output logic             ctl_req,
  output logic [CW-1:0]    ctl_char,
  output logic             rxq_wr_en,
  output logic [CW-1:0]    rxq_wr_data
);
  logic hw_act, sw_act, halted, halt_evt, resume_evt, paused;

  assign hw_act = cfg_ext_en && cfg_hw_en;
  assign sw_act = cfg_ext_en && cfg_sw_en;

  fc_rx_thresh #(.LVL_W(LVL_W)) u_thr (
    .clk(clk), .rst(rst), .enable(hw_act || sw_act), .hw_act(hw_act),
    .level(rxq_level), .halt_f(cfg_halt_lvl), .resume_f(cfg_resume_lvl),
    .halted(halted), .halt_evt(halt_evt), .resume_evt(resume_evt),
    .rts(rts_out));

  fc_sw_link #(.CHAR_W(CW)) u_sw (
    .clk(clk), .rst(rst), .sw_act(sw_act), .rx_valid(rx_valid),
    .rx_char(rx_char), .xon(cfg_xon), .xoff(cfg_xoff), .paused(paused),
    .wr_en(rxq_wr_en), .wr_data(rxq_wr_data));

  fc_tx_gate #(.CHAR_W(CW)) u_gate (
    .clk(clk), .rst(rst), .hw_act(hw_act), .sw_act(sw_act), .cts(cts_in),
    .paused(paused), .halt_evt(halt_evt), .resume_evt(resume_evt),
    .ack(ctl_ack), .xon(cfg_xon), .xoff(cfg_xoff), .req(ctl_req),
    .req_char(ctl_char), .gate(tx_gate));

  // R10: master enable off keeps the line open
  p_ext_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ext_en && $past(!cfg_ext_en)) |-> rts_out);
  // R1: after reset the handshake lines are idle
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (rts_out && !ctl_req && !rxq_wr_en));
endmodule

// File: tb/sim_flow_ctl_top.sv
module sim_flow_ctl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_ext_en = 0, cfg_hw_en = 0, cfg_sw_en = 0;
  logic [3:0] cfg_halt_lvl = 4'd8, cfg_resume_lvl = 4'd4;
  logic [7:0] cfg_xon = 8'h11, cfg_xoff = 8'h13;
  logic [6:0] rxq_level = '0;
  logic rx_valid = 0;
  logic [7:0] rx_char = '0;
  logic cts_in = 1, ctl_ack = 0;
  logic rts_out, tx_gate, ctl_req, rxq_wr_en;
  logic [7:0] ctl_char, rxq_wr_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  flow_ctl_top u0 (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(logic [7:0] c, bit expect_write);
    rx_valid = 1; rx_char = c;
    if (expect_write) exp_q.push_back(c);
    step(1);
    rx_valid = 0;
  endtask

  task automatic pulse_ack();
    ctl_ack = 1; step(1); ctl_ack = 0;
  endtask

  // monitor: compare queue writes against the scoreboard (R9, R10)
  always @(negedge clk) begin
    if (!rst && rxq_wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 got write %0h expected none", rxq_wr_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (e != rxq_wr_data) begin
          errors++;
          $display("FAIL R9 got %0h expected %0h", rxq_wr_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 rts", rts_out, 1); chk("R1 gate", tx_gate, 0);
    chk("R1 req", ctl_req, 0); chk("R1 wr", rxq_wr_en, 0);
    rst = 0;
    // hardware scheme
    cfg_ext_en = 1; cfg_hw_en = 1; step(2);
    chk("R4 gate open", tx_gate, 1);
    rxq_level = 31; step(1); chk("R2 below", rts_out, 1);
    rxq_level = 32; step(1); chk("R2 at halt", rts_out, 0);
    rxq_level = 20; step(2); chk("R3 between", rts_out, 0);
    rxq_level = 16; step(1); chk("R3 at resume", rts_out, 1);
    cts_in = 0; step(1); chk("R4 cts low", tx_gate, 0);
    cts_in = 1; step(1); chk("R4 cts high", tx_gate, 1);
    send_char(8'h13, 1); step(1);
    chk("R8 xoff ignored hw", tx_gate, 1);
    rxq_level = 0; step(2);
    // in-band scheme
    cfg_hw_en = 0; cfg_sw_en = 1; step(2);
    rxq_level = 32; step(2);
    chk("R5 xoff req", ctl_req, 1); chk("R5 xoff char", ctl_char, 8'h13);
    chk("R7 gate held", tx_gate, 0); chk("R5 rts stays", rts_out, 1);
    step(3); chk("R6 held", ctl_req, 1);
    pulse_ack(); chk("R6 released", ctl_req, 0); chk("R7 gate back", tx_gate, 1);
    rxq_level = 16; step(2);
    chk("R5 xon req", ctl_req, 1); chk("R5 xon char", ctl_char, 8'h11);
    rxq_level = 40; step(2);
    chk("R6 replaced req", ctl_req, 1); chk("R6 replaced char", ctl_char, 8'h13);
    pulse_ack(); chk("R6 ack", ctl_req, 0);
    rxq_level = 0; step(2); pulse_ack(); step(1);
    send_char(8'h13, 0); step(1); chk("R8 xoff pauses", tx_gate, 0);
    send_char(8'h41, 1); step(1); chk("R8 still paused", tx_gate, 0);
    send_char(8'h11, 0); step(1); chk("R8 xon resumes", tx_gate, 1);
    // zero halt field
    cfg_halt_lvl = 0; cfg_hw_en = 1; rxq_level = 64; step(3);
    chk("R11 rts", rts_out, 1); chk("R11 req", ctl_req, 0);
    // master enable off
    cfg_halt_lvl = 8; cfg_ext_en = 0; cts_in = 0; step(3);
    chk("R10 rts", rts_out, 1); chk("R10 gate", tx_gate, 1);
    send_char(8'h13, 1); step(2); chk("R10 gate after xoff", tx_gate, 1);
    chk("R9 scoreboard empty", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule